// File: doc/BRIEF.md
# APB4 Address-Decoding Bus Splitter

This block sits between one upstream APB4 requester and a set of downstream APB4 completers. Each downstream child is either a single address region or a one-dimensional array of equal regions placed at a power-of-two stride. The splitter compares the transfer address against every child's range. It raises the select and write strobe only on the matching completer port, and sends the shared request fields to all ports. The ready, error and read data of the chosen port come back to the requester.

An address that falls outside every child, or into the unused tail of an array element's stride slot, never reaches a completer. The splitter answers such a transfer itself. It flags an error for as long as the select is high, and it completes the transfer in the access phase that follows the setup phase. Base, size, element count and stride of every child are parameters. A configuration whose child spans overlap, whose stride is not a power of two, or whose port count does not add up stops elaboration.

Top module: `apb_addr_splitter`

## Requirements
- R1: Completer ports are numbered child by child and, within an array, by ascending element index. The default map is: port 0 at 0x0000-0x00FF; ports 1 to 4 at 0x1000+k*0x100 with 0x80 bytes each (k = 0..3); ports 5 and 6 at 0x4000+k*0x400 with 0x400 bytes each. Bit p of `m_psel` is high exactly when `psel` is high and `paddr` lies in port p's range, so `m_psel` is at most one-hot and is all zero while `psel` is low.
- R2: For an arrayed child, the element is (`paddr` - array base) / stride. An address inside the array span but at or beyond the element size within its stride slot selects no port.
- R3: Bit p of `m_pwrite` is high only when bit p of `m_psel` is high and `pwrite` is high. During a read it is zero on every port.
- R4: `m_penable`, `m_paddr`, `m_pprot`, `m_pwdata` and `m_pstrb` always equal `penable`, `paddr`, `pprot`, `pwdata` and `pstrb`, whether or not a port is selected.
- R5: While a port is selected, `pready` and `pslverr` equal that port's `m_pready` and `m_pslverr`. With `psel` low, both are zero, whatever the completers drive.
- R6: `prdata` equals the selected port's read data during a read. During a write, during an unmapped transfer and while `psel` is low, it is zero.
- R7: While `psel` is high and `paddr` maps to no port, `pslverr` is high in both the setup and the access phase.
- R8: After a setup phase (`psel` high, `penable` low) to an unmapped address, the next cycle's access phase has `pready` and `pslverr` both high. A write to an unmapped address is therefore answered one cycle after its setup phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Upstream select |
| penable | input | 1 | Upstream access-phase strobe |
| pwrite | input | 1 | Upstream direction, high for write |
| paddr | input | ADDR_W | Upstream address |
| pprot | input | 3 | Upstream protection attributes |
| pwdata | input | DATA_W | Upstream write data |
| pstrb | input | DATA_W/8 | Upstream byte strobes |
| prdata | output | DATA_W | Read data returned upstream |
| pready | output | 1 | Transfer completion upstream |
| pslverr | output | 1 | Error response upstream |
| m_psel | output | N_PORT | Per-port select |
| m_pwrite | output | N_PORT | Per-port write strobe |
| m_penable | output | 1 | Shared access-phase strobe |
| m_paddr | output | ADDR_W | Shared address |
| m_pprot | output | 3 | Shared protection attributes |
| m_pwdata | output | DATA_W | Shared write data |
| m_pstrb | output | DATA_W/8 | Shared byte strobes |
| m_pready | input | N_PORT | Per-port ready |
| m_pslverr | input | N_PORT | Per-port error |
| m_prdata | input | N_PORT*DATA_W | Per-port read data, port p at bits p*DATA_W upward |

## Verification
Reads and writes are aimed at the first and last byte of every single region and every array element. This separates an off-by-one in the span comparison from an error in the element-index arithmetic. Addresses are also placed just past each element's size inside its stride slot, just past each span, and at the top of the address space. These separate a gap correctly left unmapped from one wrongly treated as belonging to its element. One completer is made to report an error and another to hold ready low, so the response is shown to come from the selected port and not from a merge of all ports. Back-to-back transfers, with no idle cycle between an unmapped access and the next transfer, check that the locally generated completion does not leak into the following transfer.

// File: rtl/apbs_pkg.sv
package apbs_pkg;

  // Upstream response pair assembled by the fan-in stage.
  typedef struct packed {
    logic ready;
    logic err;
  } apbs_resp_t;

  function automatic bit apbs_is_pow2(longint unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/apbs_decode.sv
// Range decode: span check per child, then element slot check per array element.
module apbs_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned N_CHILD = 3,
  parameter int unsigned N_PORT  = 7,
  parameter int unsigned CH_BASE   [N_CHILD] = '{32'h0000, 32'h1000, 32'h4000},
  parameter int unsigned CH_COUNT  [N_CHILD] = '{1, 4, 2},
  parameter int unsigned CH_STRIDE [N_CHILD] = '{32'h100, 32'h100, 32'h400},
  parameter int unsigned CH_ESIZE  [N_CHILD] = '{32'h100, 32'h80, 32'h400}
) (
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [N_PORT-1:0] wr_sel,
  output logic [N_PORT-1:0] rd_sel,
  output logic              miss
);

  localparam int unsigned XW = ADDR_W + 1;

  // First port number owned by child c.
  function automatic int unsigned port_base(int unsigned c);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < c; k++) acc += CH_COUNT[k];
    return acc;
  endfunction

  logic [N_PORT-1:0] hit;
  logic [XW-1:0]     addr_x;

  assign addr_x = {1'b0, paddr};

  for (genvar c = 0; c < N_CHILD; c++) begin : g_child
    localparam int unsigned OFS = port_base(c);
    localparam int unsigned CNT = CH_COUNT[c];
    localparam int unsigned SH  = $clog2(CH_STRIDE[c]);
    localparam logic [XW-1:0] BASE_X = XW'(CH_BASE[c]);
    localparam logic [XW-1:0] END_X  =
      XW'(longint'(CH_BASE[c]) + longint'(CNT) * longint'(CH_STRIDE[c]));
    localparam logic [XW-1:0] ESZ_X  = XW'(CH_ESIZE[c]);
    localparam logic [XW-1:0] MSK_X  = XW'(CH_STRIDE[c] - 1);

    logic          in_span;
    logic          in_elem;
    logic [XW-1:0] off;
    logic [XW-1:0] idx;

    assign in_span = (addr_x >= BASE_X) && (addr_x < END_X);
    assign off     = addr_x - BASE_X;
    assign in_elem = (off & MSK_X) < ESZ_X;
    assign idx     = off >> SH;

    for (genvar e = 0; e < CNT; e++) begin : g_elem
      assign hit[OFS+e] = in_span && in_elem && (idx == XW'(e));
    end
  end

  assign wr_sel = hit & {N_PORT{psel &  pwrite}};
  assign rd_sel = hit & {N_PORT{psel & ~pwrite}};
  assign miss   = psel & ~(|hit);

endmodule

// File: rtl/apbs_fanout.sv
// Per-port strobe gating toward the completers.
module apbs_fanout #(
  parameter int unsigned N_PORT = 7
) (
  input  logic [N_PORT-1:0] wr_sel,
  input  logic [N_PORT-1:0] rd_sel,
  output logic [N_PORT-1:0] psel_o,
  output logic [N_PORT-1:0] pwrite_o
);

  assign psel_o   = wr_sel | rd_sel;
  assign pwrite_o = wr_sel;

endmodule

// File: rtl/apbs_fanin.sv
// AND-OR return path from the one-hot selected port, plus the local error reply.
module apbs_fanin
  import apbs_pkg::*;
#(
  parameter int unsigned N_PORT = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic [N_PORT-1:0]        sel_any,
  input  logic [N_PORT-1:0]        rd_sel,
  input  logic [N_PORT-1:0]        s_ready,
  input  logic [N_PORT-1:0]        s_err,
  input  logic [N_PORT*DATA_W-1:0] s_rdata,
  input  logic                     miss,
  input  logic                     miss_q,
  input  logic                     psel,
  input  logic                     penable,
  output apbs_resp_t               resp,
  output logic [DATA_W-1:0]        rdata
);

  always_comb begin
    resp  = '0;
    rdata = '0;
    for (int unsigned p = 0; p < N_PORT; p++) begin
      if (sel_any[p]) begin
        resp.ready = resp.ready | s_ready[p];
        resp.err   = resp.err   | s_err[p];
      end
      if (rd_sel[p]) rdata = rdata | s_rdata[p*DATA_W +: DATA_W];
    end
    resp.err   = resp.err   | miss;
    resp.ready = resp.ready | (miss_q & psel & penable);
  end

endmodule

// File: rtl/apb_addr_splitter.sv
module apb_addr_splitter
  import apbs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_CHILD = 3,
  parameter int unsigned N_PORT  = 7,
  parameter int unsigned CH_BASE   [N_CHILD] = '{32'h0000, 32'h1000, 32'h4000},
  parameter int unsigned CH_COUNT  [N_CHILD] = '{1, 4, 2},
  parameter int unsigned CH_STRIDE [N_CHILD] = '{32'h100, 32'h100, 32'h400},
  parameter int unsigned CH_ESIZE  [N_CHILD] = '{32'h100, 32'h80, 32'h400}
) (
  input  logic                     pclk,
  input  logic                     presetn,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [2:0]               pprot,
  input  logic [DATA_W-1:0]        pwdata,
  input  logic [DATA_W/8-1:0]      pstrb,
  output logic [DATA_W-1:0]        prdata,
  output logic                     pready,
  output logic                     pslverr,
  output logic [N_PORT-1:0]        m_psel,
  output logic [N_PORT-1:0]        m_pwrite,
  output logic                     m_penable,
  output logic [ADDR_W-1:0]        m_paddr,
  output logic [2:0]               m_pprot,
  output logic [DATA_W-1:0]        m_pwdata,
  output logic [DATA_W/8-1:0]      m_pstrb,
  input  logic [N_PORT-1:0]        m_pready,
  input  logic [N_PORT-1:0]        m_pslverr,
  input  logic [N_PORT*DATA_W-1:0] m_prdata
);

  // Elaboration-time sanity of the child map.
  function automatic bit cfg_ok();
    bit              ok;
    longint unsigned total;
    longint unsigned lo_a;
    longint unsigned hi_a;
    longint unsigned lo_b;
    longint unsigned hi_b;
    ok    = 1'b1;
    total = 0;
    for (int unsigned c = 0; c < N_CHILD; c++) begin
      total += CH_COUNT[c];
      if (!apbs_is_pow2(CH_STRIDE[c]) || CH_ESIZE[c] == 0 ||
          CH_ESIZE[c] > CH_STRIDE[c] || CH_COUNT[c] == 0) ok = 1'b0;
      lo_a = CH_BASE[c];
      hi_a = lo_a + longint'(CH_COUNT[c]) * longint'(CH_STRIDE[c]);
      if (hi_a > (64'd1 << ADDR_W)) ok = 1'b0;
      for (int unsigned d = c + 1; d < N_CHILD; d++) begin
        lo_b = CH_BASE[d];
        hi_b = lo_b + longint'(CH_COUNT[d]) * longint'(CH_STRIDE[d]);
        if (lo_a < hi_b && lo_b < hi_a) ok = 1'b0;
      end
    end
    if (total != N_PORT) ok = 1'b0;
    return ok;
  endfunction

  localparam bit CFG_OK = cfg_ok();

  if (!CFG_OK) begin : g_cfg_bad
    $error("apb_addr_splitter: child map overlaps or is inconsistent");
  end

  logic [N_PORT-1:0] wr_sel;
  logic [N_PORT-1:0] rd_sel;
  logic [N_PORT-1:0] sel_any;
  logic              miss;
  logic              miss_q;
  logic              miss_nxt;
  logic              miss_en;
  apbs_resp_t        resp;

  apbs_decode #(
    .ADDR_W   (ADDR_W),
    .N_CHILD  (N_CHILD),
    .N_PORT   (N_PORT),
    .CH_BASE  (CH_BASE),
    .CH_COUNT (CH_COUNT),
    .CH_STRIDE(CH_STRIDE),
    .CH_ESIZE (CH_ESIZE)
  ) u_decode (
    .psel  (psel),
    .pwrite(pwrite),
    .paddr (paddr),
    .wr_sel(wr_sel),
    .rd_sel(rd_sel),
    .miss  (miss)
  );

  apbs_fanout #(.N_PORT(N_PORT)) u_fanout (
    .wr_sel  (wr_sel),
    .rd_sel  (rd_sel),
    .psel_o  (sel_any),
    .pwrite_o(m_pwrite)
  );

  assign m_psel    = sel_any;
  assign m_penable = penable;
  assign m_paddr   = paddr;
  assign m_pprot   = pprot;
  assign m_pwdata  = pwdata;
  assign m_pstrb   = pstrb;

  // Unmapped setup phase is remembered so the completion is taken from a flop.
  always_comb begin
    miss_en  = psel | miss_q;
    miss_nxt = psel & ~penable & miss;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      miss_q <= 1'b0;
    end else if (miss_en) begin
      miss_q <= miss_nxt;
    end
  end

  apbs_fanin #(
    .N_PORT(N_PORT),
    .DATA_W(DATA_W)
  ) u_fanin (
    .sel_any(sel_any),
    .rd_sel (rd_sel),
    .s_ready(m_pready),
    .s_err  (m_pslverr),
    .s_rdata(m_prdata),
    .miss   (miss),
    .miss_q (miss_q),
    .psel   (psel),
    .penable(penable),
    .resp   (resp),
    .rdata  (prdata)
  );

  assign pready  = resp.ready;
  assign pslverr = resp.err;

endmodule

// File: rtl/apbs_checker.sv
module apbs_checker #(
  parameter int unsigned N_PORT = 7,
  parameter int unsigned DATA_W = 32
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [N_PORT-1:0] m_psel,
  input logic [N_PORT-1:0] m_pwrite,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] prdata
);

  p_onehot_r1: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(m_psel));

  p_idle_nosel_r1: assert property (@(posedge pclk) disable iff (!presetn)
    !psel |-> (m_psel == '0));

  p_rd_nowr_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite) |-> (m_pwrite == '0));

  p_wr_follow_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && pwrite) |-> (m_pwrite == m_psel));

  p_idle_resp_r5: assert property (@(posedge pclk) disable iff (!presetn)
    !psel |-> (!pready && !pslverr));

  p_rdata_zero_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (!psel || pwrite) |-> (prdata == '0));

  p_unmapped_err_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && m_psel == '0) |-> pslverr);

  p_wr_answer_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && pwrite && !penable && m_psel == '0) |=> (pready && pslverr));

  p_rd_answer_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && !penable && m_psel == '0) |=> (pready && pslverr));

endmodule

bind apb_addr_splitter apbs_checker #(
  .N_PORT(N_PORT),
  .DATA_W(DATA_W)
) u_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .m_psel  (m_psel),
  .m_pwrite(m_pwrite),
  .pready  (pready),
  .pslverr (pslverr),
  .prdata  (prdata)
);

// File: tb/sim_apb_addr_splitter.sv
module sim_apb_addr_splitter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NP = 7;

  logic          pclk = 1'b0;
  logic          presetn;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [2:0]    pprot;
  logic [DW-1:0] pwdata;
  logic [3:0]    pstrb;
  logic [DW-1:0] prdata;
  logic          pready, pslverr;
  logic [NP-1:0] m_psel, m_pwrite;
  logic          m_penable;
  logic [AW-1:0] m_paddr;
  logic [2:0]    m_pprot;
  logic [DW-1:0] m_pwdata;
  logic [3:0]    m_pstrb;
  logic [NP-1:0] c_rdy, c_err;
  logic [NP*DW-1:0] c_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit exp_miss_q;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_addr_splitter u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pprot(pprot), .pwdata(pwdata),
    .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .m_psel(m_psel), .m_pwrite(m_pwrite), .m_penable(m_penable),
    .m_paddr(m_paddr), .m_pprot(m_pprot), .m_pwdata(m_pwdata),
    .m_pstrb(m_pstrb), .m_pready(c_rdy), .m_pslverr(c_err),
    .m_prdata(c_rdata)
  );

  // Address map from R1: returns the port number, or -1 when unmapped.
  function automatic int map_port(logic [AW-1:0] a);
    int r;
    r = -1;
    if (a < 16'h0100) r = 0;
    for (int k = 0; k < 4; k++)
      if (a >= 16'h1000 + k*16'h100 && a < 16'h1000 + k*16'h100 + 16'h80) r = 1 + k;
    for (int k = 0; k < 2; k++)
      if (a >= 16'h4000 + k*16'h400 && a < 16'h4400 + k*16'h400) r = 5 + k;
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference state: an unmapped setup phase seen at the last edge.
  always @(posedge pclk or negedge presetn) begin
    if (!presetn) exp_miss_q <= 1'b0;
    else          exp_miss_q <= psel && !penable && (map_port(paddr) < 0);
  end

  // Compare every output each cycle, away from the active edge.
  always @(negedge pclk) begin : model
    int            p;
    bit            hit, unm, gap;
    logic [NP-1:0] e_sel, e_wr;
    logic          e_rdy, e_err;
    logic [DW-1:0] e_rd;
    p   = map_port(paddr);
    hit = psel && (p >= 0);
    unm = psel && (p < 0);
    gap = (paddr >= 16'h1000) && (paddr < 16'h1400) && (p < 0);
    e_sel = hit ? NP'(1 << p) : '0;
    e_wr  = (hit && pwrite) ? NP'(1 << p) : '0;
    e_rdy = hit ? c_rdy[p] : (unm && penable && exp_miss_q);
    e_err = hit ? c_err[p] : unm;
    e_rd  = (hit && !pwrite) ? c_rdata[p*DW +: DW] : '0;
    if (gap) chk("R2", "m_psel gap", 64'(m_psel), 64'(e_sel));
    else     chk("R1", "m_psel", 64'(m_psel), 64'(e_sel));
    chk("R3", "m_pwrite", 64'(m_pwrite), 64'(e_wr));
    chk("R4", "broadcast", {m_penable, m_pprot, m_pstrb, m_paddr, m_pwdata},
        {penable, pprot, pstrb, paddr, pwdata});
    if (unm) begin
      chk("R7", "pslverr unmapped", 64'(pslverr), 64'(e_err));
      chk("R8", "pready unmapped", 64'(pready), 64'(e_rdy));
    end else begin
      chk("R5", "pslverr", 64'(pslverr), 64'(e_err));
      chk("R5", "pready", 64'(pready), 64'(e_rdy));
    end
    chk("R6", "prdata", 64'(prdata), 64'(e_rd));
  end

  task automatic drive(logic s, logic en, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(posedge pclk);
    #1;
    psel = s; penable = en; pwrite = w; paddr = a; pwdata = d;
    pstrb = w ? 4'hF : 4'h0; pprot = a[2:0];
  endtask

  task automatic xfer(logic w, logic [AW-1:0] a);
    drive(1'b1, 1'b0, w, a, {a, ~a});
    drive(1'b1, 1'b1, w, a, {a, ~a});
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, paddr, pwdata);
  endtask

  logic [AW-1:0] addrs [20] = '{
    16'h0000, 16'h00FF, 16'h0100, 16'h0FFF,
    16'h1000, 16'h107F, 16'h1080, 16'h10FF,
    16'h1100, 16'h1280, 16'h1300, 16'h137F,
    16'h13FF, 16'h1400, 16'h4000, 16'h43FF,
    16'h4400, 16'h47FF, 16'h4800, 16'hFFFF };

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    presetn = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pprot = '0; pwdata = '0; pstrb = '0;
    c_rdy = '1; c_err = '0;
    for (int p = 0; p < NP; p++) c_rdata[p*DW +: DW] = 32'hD000_0000 + p * 32'h0011_0101;
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;
    idle();
    // Reads and writes across every boundary (R1, R2, R6, R7, R8).
    for (int i = 0; i < 20; i++) begin
      xfer(1'b0, addrs[i]);
      idle();
      xfer(1'b1, addrs[i]);
      idle();
    end
    // Selected child's own error and wait state (R5).
    c_err[3] = 1'b1;
    c_rdy[5] = 1'b0;
    xfer(1'b0, 16'h1200);
    idle();
    xfer(1'b1, 16'h4010);
    idle();
    // Idle with completers asserting responses: must not pass up (R5).
    c_err = '1;
    repeat (2) idle();
    c_err = '0;
    c_rdy = '1;
    // Back-to-back, unmapped then mapped then unmapped (R8).
    xfer(1'b1, 16'h2000);
    xfer(1'b0, 16'h0040);
    xfer(1'b0, 16'h1090);
    xfer(1'b1, 16'h4500);
    idle();
    repeat (2) @(posedge pclk);
    @(negedge pclk);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule